// File: doc/BRIEF.md
# Rotating hub slot arbiter

This block shares one word-addressed memory among sixteen requesting cores without a queue. The memory is split into sixteen banks by the low nibble of the word address. A global slot counter advances by one every clock, and in any clock core k owns exactly one bank, number (k + slot) mod 16. A core's access can fire only in a clock where the bank its address selects is the bank that core owns. The wait for a single access therefore depends on the address, the core number and the slot value at the moment the request appears.

Each core has one request port: valid, write, block, address and write data. It gets back read data, a per-word beat strobe, a lane index and a done strobe. A core keeps valid high until done pulses and has at most one request in flight. A block request walks every bank of an aligned group of sixteen words, one bank per clock, in ascending bank order. It can read the group or write it, and it finishes in sixteen clocks whatever the slot value. The banks are plain register storage inside the block and are cleared by reset.

Top module: `hub_slot_arbiter`

## Requirements
- R1: `slotRot` is 0 while reset is held and in the first clock after reset. It rises by one each clock and wraps from 15 to 0.
- R2: Core k serves a single (non-block) request for word address A in the first clock, counted from the clock the request is presented, in which (k + slotRot) mod 16 equals A[3:0]. rspDone therefore goes high ((A[3:0] - k - slotRot) mod 16) + 1 clocks after presentation, with slotRot taken in the presenting clock.
- R3: rspBeat and rspDone of a single request rise together in the clock after the served slot and stay high for one clock. rspLane then holds A[3:0], and for a read rspData holds the stored word at A.
- R4: A single write stores reqWdata at word A, and a later read returns it. Every word reads as zero after reset.
- R5: rspDone for a single request goes high no more than 16 clocks after the request is presented.
- R6: A request is not served in a clock in which its own rspDone is high. A read of A+1 presented in the clock where the read of A completes therefore finishes 17 clocks later.
- R7: A block read (reqBlock=1, reqWrite=0) gives 16 beats on consecutive clocks, starting the clock after presentation. Lanes ascend mod 16 from (k + slotRot), each rspData is the word at row A[7:4] in that lane, and rspDone comes with the 16th beat only.
- R8: A block write stores, in each clock of its sweep, the reqWdata of that clock at row A[7:4], lane (k + slotRot) mod 16. It gives 16 beats and then done.
- R9: While reqValid is low, nothing is stored and no beat or done is produced, whatever the other request inputs hold.
- R10: Two cores that address the same bank in different rows at the same time are each served on their own slot, with no effect on each other's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 16 | Per-core request valid, held until done |
| reqWrite | input | 16 | Per-core write (1) or read (0) |
| reqBlock | input | 16 | Per-core block sweep of an aligned 16-word group |
| reqAddr | input | 16*ADDR_W | Per-core word address, core k at bits k*ADDR_W |
| reqWdata | input | 16*DATA_W | Per-core write data, sampled in the served clock |
| slotRot | output | 4 | Current rotation value |
| rspBeat | output | 16 | Per-core strobe for one transferred word |
| rspDone | output | 16 | Per-core strobe for request completion |
| rspLane | output | 64 | Per-core bank index of the last beat, 4 bits per core |
| rspData | output | 16*DATA_W | Per-core registered read data |

## Verification
The bench aims at the slot arithmetic. It predicts the completion clock of every single access from its own rotation count, and it places one request so that it needs the longest wait of sixteen clocks. A wrong mapping between core, slot and bank, or an extra register stage, moves the completion clock and is reported. The sequential-address case checks that a core cannot reuse the clock in which its done is high: a design without that gate would finish the next read almost at once, or would fire a stale request twice. Block sweeps that start part way through a group check that the lane order wraps and that done comes on the 16th beat, and the bench also checks that a request with valid low writes nothing and that two cores sharing a bank do not affect each other.

// File: rtl/hub_slot_pkg.sv
package hub_slot_pkg;
  localparam int SLOT_BITS = 4;
  localparam int SLOTS = 1 << SLOT_BITS;

  typedef logic [SLOT_BITS-1:0] slot_t;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic [SLOTS-1:0] fire;
    logic [SLOTS-1:0] wr;
    slot_t            rot;
  } hub_strobe_t;
endpackage

// File: rtl/hub_slot_ctrl.sv
module hub_slot_ctrl
  import hub_slot_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SLOTS-1:0]           reqValid,
  input  logic [SLOTS-1:0]           reqWrite,
  input  logic [SLOTS-1:0]           reqBlock,
  input  logic [SLOTS*SLOT_BITS-1:0] reqLane,
  output hub_strobe_t                strobe,
  output logic [SLOT_BITS-1:0]       slotRot,
  output logic [SLOTS-1:0]           rspBeat,
  output logic [SLOTS-1:0]           rspDone,
  output logic [SLOTS*SLOT_BITS-1:0] rspLane
);
  slot_t rotQ;
  logic [SLOTS-1:0] fireVec;

  always_ff @(posedge clk) begin
    if (rst) rotQ <= '0;
    else     rotQ <= rotQ + slot_t'(1);
  end

  assign slotRot = rotQ;
  assign strobe  = '{fire: fireVec, wr: reqWrite, rot: rotQ};

  for (genvar k = 0; k < SLOTS; k++) begin : gen_core
    slot_t ownBank;
    slot_t wantBank;
    slot_t beatQ;
    slot_t laneQ;
    logic  doneQ;
    logic  beatOutQ;
    logic  active;
    logic  lastBeat;

    assign ownBank  = slot_t'(k) + rotQ;
    assign wantBank = reqLane[k*SLOT_BITS +: SLOT_BITS];
    // the clock showing done is never reused for a new access
    assign active   = reqValid[k] & ~doneQ;
    assign fireVec[k] = active & (reqBlock[k] | (wantBank == ownBank));
    assign lastBeat = ~reqBlock[k] | (&beatQ);

    always_ff @(posedge clk) begin
      if (rst) begin
        beatQ    <= '0;
        laneQ    <= '0;
        doneQ    <= 1'b0;
        beatOutQ <= 1'b0;
      end else begin
        doneQ    <= fireVec[k] & lastBeat;
        beatOutQ <= fireVec[k];
        if (fireVec[k]) laneQ <= ownBank;
        if (!reqValid[k])                   beatQ <= '0;
        else if (fireVec[k] && reqBlock[k]) beatQ <= beatQ + slot_t'(1);
      end
    end

    assign rspDone[k] = doneQ;
    assign rspBeat[k] = beatOutQ;
    assign rspLane[k*SLOT_BITS +: SLOT_BITS] = laneQ;
  end
endmodule

// File: rtl/hub_slot_datapath.sv
module hub_slot_datapath
  import hub_slot_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  hub_strobe_t               strobe,
  input  logic [SLOTS*ROW_BITS-1:0] reqRow,
  input  logic [SLOTS*DATA_W-1:0]   reqWdata,
  output logic [SLOTS*DATA_W-1:0]   rspData
);
  localparam int ROWS = 1 << ROW_BITS;

  logic [ROW_BITS-1:0] rowOf   [SLOTS];
  logic [DATA_W-1:0]   wdataOf [SLOTS];
  logic [DATA_W-1:0]   bankRd  [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : gen_unpack
    assign rowOf[k]   = reqRow[k*ROW_BITS +: ROW_BITS];
    assign wdataOf[k] = reqWdata[k*DATA_W +: DATA_W];
  end

  // one storage bank per slot; exactly one core owns it in any clock
  for (genvar b = 0; b < SLOTS; b++) begin : gen_bank
    logic [DATA_W-1:0] cells [ROWS];
    slot_t owner;

    assign owner     = slot_t'(b) - strobe.rot;
    assign bankRd[b] = cells[rowOf[owner]];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < ROWS; r++) cells[r] <= '0;
      end else if (strobe.fire[owner] && strobe.wr[owner]) begin
        cells[rowOf[owner]] <= wdataOf[owner];
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : gen_read
    logic [DATA_W-1:0] rdQ;
    always_ff @(posedge clk) begin
      if (rst)                                     rdQ <= '0;
      else if (strobe.fire[k] && !strobe.wr[k])    rdQ <= bankRd[slot_t'(k) + strobe.rot];
    end
    assign rspData[k*DATA_W +: DATA_W] = rdQ;
  end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
  import hub_slot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SLOTS-1:0]           reqValid,
  input  logic [SLOTS-1:0]           reqWrite,
  input  logic [SLOTS-1:0]           reqBlock,
  input  logic [SLOTS*ADDR_W-1:0]    reqAddr,
  input  logic [SLOTS*DATA_W-1:0]    reqWdata,
  output logic [SLOT_BITS-1:0]       slotRot,
  output logic [SLOTS-1:0]           rspBeat,
  output logic [SLOTS-1:0]           rspDone,
  output logic [SLOTS*SLOT_BITS-1:0] rspLane,
  output logic [SLOTS*DATA_W-1:0]    rspData
);
  localparam int ROW_BITS = ADDR_W - SLOT_BITS;

  logic [SLOTS*SLOT_BITS-1:0] reqLane;
  logic [SLOTS*ROW_BITS-1:0]  reqRow;
  hub_strobe_t                strobe;

  for (genvar k = 0; k < SLOTS; k++) begin : gen_split
    assign reqLane[k*SLOT_BITS +: SLOT_BITS] = reqAddr[k*ADDR_W +: SLOT_BITS];
    assign reqRow[k*ROW_BITS +: ROW_BITS]    = reqAddr[k*ADDR_W + SLOT_BITS +: ROW_BITS];
  end

  hub_slot_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqBlock (reqBlock),
    .reqLane  (reqLane),
    .strobe   (strobe),
    .slotRot  (slotRot),
    .rspBeat  (rspBeat),
    .rspDone  (rspDone),
    .rspLane  (rspLane)
  );

  hub_slot_datapath #(.ROW_BITS(ROW_BITS), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqRow   (reqRow),
    .reqWdata (reqWdata),
    .rspData  (rspData)
  );
endmodule

// File: rtl/hub_slot_arbiter_checker.sv
module hub_slot_arbiter_checker
  import hub_slot_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic [SLOT_BITS-1:0]       slotRot,
  input logic [SLOTS-1:0]           reqValid,
  input logic [SLOTS-1:0]           rspBeat,
  input logic [SLOTS-1:0]           rspDone,
  input logic [SLOTS*SLOT_BITS-1:0] rspLane
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_rot_step_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> slotRot == $past(slotRot) + 4'd1);

  for (genvar k = 0; k < SLOTS; k++) begin : gen_chk
    logic [4:0] waitQ;
    always_ff @(posedge clk) begin
      if (rst || !reqValid[k] || rspDone[k]) waitQ <= '0;
      else if (waitQ != 5'd31)               waitQ <= waitQ + 5'd1;
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      rspDone[k] |=> !rspDone[k]);

    assert_done_after_valid_R3: assert property (@(posedge clk) disable iff (rst)
      rspDone[k] |-> $past(reqValid[k]));

    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
      waitQ <= 5'd16);

    assert_lane_step_R7: assert property (@(posedge clk) disable iff (rst)
      (rspBeat[k] && !rspDone[k]) |=>
        (rspBeat[k] && rspLane[k*SLOT_BITS +: SLOT_BITS] ==
         $past(rspLane[k*SLOT_BITS +: SLOT_BITS]) + 4'd1));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(reqValid[k]) |-> !rspBeat[k]);
  end
endmodule

bind hub_slot_arbiter hub_slot_arbiter_checker chk (
  .clk      (clk),
  .rst      (rst),
  .slotRot  (slotRot),
  .reqValid (reqValid),
  .rspBeat  (rspBeat),
  .rspDone  (rspDone),
  .rspLane  (rspLane)
);

// File: tb/hub_slot_arbiter_test.sv
module hub_slot_arbiter_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NC-1:0]    reqValid, reqWrite, reqBlock;
  logic [NC*AW-1:0] reqAddr;
  logic [NC*DW-1:0] reqWdata;
  logic [3:0]       slotRot;
  logic [NC-1:0]    rspBeat, rspDone;
  logic [NC*4-1:0]  rspLane;
  logic [NC*DW-1:0] rspData;

  logic [NC-1:0] vValid = '0, vWrite = '0, vBlock = '0, vBlkW = '0;
  logic [AW-1:0] vAddr [NC];
  logic [DW-1:0] vData [NC];
  logic [3:0]    rotModel;
  logic [DW-1:0] model [256];
  int checks = 0;
  int fails  = 0;

  hub_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBlock(reqBlock), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .slotRot(slotRot), .rspBeat(rspBeat), .rspDone(rspDone),
    .rspLane(rspLane), .rspData(rspData)
  );

  function automatic logic [DW-1:0] blkPat(input logic [3:0] grp, input logic [3:0] lane);
    return {16'hB10C, 4'h0, grp, 4'h0, lane};
  endfunction

  always @(posedge clk) rotModel <= rst ? 4'd0 : rotModel + 4'd1;

  always_comb begin
    reqValid = vValid;
    reqWrite = vWrite;
    reqBlock = vBlock;
    for (int k = 0; k < NC; k++) begin
      reqAddr[k*AW +: AW]  = vAddr[k];
      reqWdata[k*DW +: DW] = vBlkW[k] ? blkPat(vAddr[k][7:4], 4'(k) + rotModel) : vData[k];
    end
  end

  // {core, write, addr, data}
  localparam logic [63:0] VEC [12] = '{
    {8'd0,  8'd1, 16'h0000, 32'h1111_0000},
    {8'd5,  8'd1, 16'h0013, 32'hA5A5_0013},
    {8'd15, 8'd1, 16'h00FF, 32'hDEAD_00FF},
    {8'd7,  8'd1, 16'h0047, 32'h0707_0047},
    {8'd0,  8'd0, 16'h0013, 32'h0},
    {8'd9,  8'd0, 16'h0000, 32'h0},
    {8'd3,  8'd0, 16'h00FF, 32'h0},
    {8'd12, 8'd0, 16'h0047, 32'h0},
    {8'd1,  8'd1, 16'h0013, 32'h5555_1313},
    {8'd14, 8'd0, 16'h0013, 32'h0},
    {8'd2,  8'd0, 16'h0080, 32'h0},
    {8'd6,  8'd0, 16'h000F, 32'h0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic doSingle(input int k, input bit wr, input logic [AW-1:0] a0,
                          input logic [DW-1:0] d, input bit worst);
    int n;
    int expEdges;
    logic [AW-1:0] a;
    logic [3:0] w;
    @(negedge clk);
    a = a0;
    if (worst) a[3:0] = 4'(k) + rotModel - 4'd1;
    w = a[3:0] - 4'(k) - rotModel;
    expEdges = int'(w) + 1;
    vValid[k] = 1'b1; vWrite[k] = wr; vBlock[k] = 1'b0; vAddr[k] = a; vData[k] = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!rspDone[k] && n < 40);
    check(n == expEdges, "R2 done clock", n, expEdges);
    check(n <= 16, "R5 wait bound", n, 16);
    check(rspBeat[k] && rspLane[k*4 +: 4] == a[3:0], "R3 beat/lane", rspLane[k*4 +: 4], a[3:0]);
    if (wr) model[a] = d;
    else check(rspData[k*DW +: DW] == model[a], "R4 read data", rspData[k*DW +: DW], model[a]);
    vValid[k] = 1'b0; vWrite[k] = 1'b0;
    @(negedge clk);
    check(!rspDone[k] && !rspBeat[k], "R3 one-clock pulse", rspDone[k], 0);
  endtask

  task automatic doBlock(input int k, input bit wr, input logic [AW-1:0] base);
    int n;
    int beats;
    logic [3:0] r0;
    logic [3:0] lane;
    bit doneEarly;
    @(negedge clk);
    r0 = rotModel;
    vValid[k] = 1'b1; vBlock[k] = 1'b1; vWrite[k] = wr; vBlkW[k] = wr; vAddr[k] = base;
    n = 0; beats = 0; doneEarly = 0;
    do begin
      @(negedge clk); n++;
      if (rspBeat[k]) begin
        lane = 4'(k) + r0 + 4'(beats);
        if (!wr) begin
          check(rspLane[k*4 +: 4] == lane, "R7 lane order", rspLane[k*4 +: 4], lane);
          check(rspData[k*DW +: DW] == model[{base[7:4], lane}], "R7 block data",
                rspData[k*DW +: DW], model[{base[7:4], lane}]);
        end
        beats++;
        if (rspDone[k] && beats != 16) doneEarly = 1;
      end
    end while (!rspDone[k] && n < 40);
    check(beats == 16 && n == 16 && !doneEarly, wr ? "R8 block write beats" : "R7 block beats", beats, 16);
    if (wr) for (int l = 0; l < 16; l++) model[{base[7:4], 4'(l)}] = blkPat(base[7:4], 4'(l));
    vValid[k] = 1'b0; vBlock[k] = 1'b0; vWrite[k] = 1'b0; vBlkW[k] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    for (int k = 0; k < NC; k++) begin vAddr[k] = '0; vData[k] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(slotRot == 4'd0, "R1 reset rotation", slotRot, 0);
    check(rspDone == '0 && rspBeat == '0, "R3 reset strobes", rspDone, 0);
    rst = 1'b0;
    check(slotRot == 4'd0, "R1 first clock", slotRot, 0);
    for (int i = 0; i < 20; i++) begin
      logic [3:0] prev;
      prev = slotRot;
      @(negedge clk);
      check(slotRot == prev + 4'd1, "R1 step and wrap", slotRot, prev + 4'd1);
    end

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic [63:0] e;
      e = VEC[i];
      doSingle(int'(e[63:56]), e[48], e[39:32], e[31:0], 1'b0);
    end

    // R5 longest wait
    doSingle(10, 1'b0, 8'h40, '0, 1'b1);

    // R6 next sequential address presented in the done clock
    begin
      int n;
      @(negedge clk);
      vValid[4] = 1'b1; vWrite[4] = 1'b0; vAddr[4] = 8'h12;
      n = 0;
      do begin @(negedge clk); n++; end while (!rspDone[4] && n < 40);
      vAddr[4] = 8'h13;
      n = 0;
      do begin @(negedge clk); n++; end while (!rspDone[4] && n < 40);
      check(n == 17, "R6 sequential wait", n, 17);
      check(rspData[4*DW +: DW] == model[8'h13], "R6 sequential data", rspData[4*DW +: DW], model[8'h13]);
      vValid[4] = 1'b0;
    end

    // R9 valid low: nothing happens
    begin
      bit sawBeat;
      sawBeat = 0;
      @(negedge clk);
      vWrite[4] = 1'b1; vAddr[4] = 8'h13; vData[4] = 32'hFFFF_FFFF;
      repeat (20) begin @(negedge clk); if (rspBeat[4] || rspDone[4]) sawBeat = 1; end
      check(!sawBeat, "R9 no beat without valid", sawBeat, 0);
      vWrite[4] = 1'b0;
      doSingle(4, 1'b0, 8'h13, '0, 1'b0);
      check(model[8'h13] == 32'h5555_1313, "R9 word kept", model[8'h13], 32'h5555_1313);
    end

    // R10 two cores, same bank, different rows
    begin
      int n, t3, t9, e3, e9;
      @(negedge clk);
      e3 = int'(4'(4'd5 - 4'd3 - rotModel)) + 1;
      e9 = int'(4'(4'd5 - 4'd9 - rotModel)) + 1;
      vValid[3] = 1'b1; vWrite[3] = 1'b1; vAddr[3] = 8'h25; vData[3] = 32'h3333_0025;
      vValid[9] = 1'b1; vWrite[9] = 1'b1; vAddr[9] = 8'h35; vData[9] = 32'h9999_0035;
      n = 0; t3 = 0; t9 = 0;
      do begin
        @(negedge clk); n++;
        if (rspDone[3]) begin t3 = n; vValid[3] = 1'b0; vWrite[3] = 1'b0; end
        if (rspDone[9]) begin t9 = n; vValid[9] = 1'b0; vWrite[9] = 1'b0; end
      end while ((t3 == 0 || t9 == 0) && n < 40);
      check(t3 == e3, "R10 core3 timing", t3, e3);
      check(t9 == e9, "R10 core9 timing", t9, e9);
      model[8'h25] = 32'h3333_0025;
      model[8'h35] = 32'h9999_0035;
      doSingle(11, 1'b0, 8'h25, '0, 1'b0);
      doSingle(0, 1'b0, 8'h35, '0, 1'b0);
    end

    // R7 / R8 block sweeps
    doBlock(6, 1'b1, 8'hA0);
    doBlock(13, 1'b0, 8'hA0);
    doBlock(2, 1'b0, 8'h10);
    doSingle(8, 1'b0, 8'hA7, '0, 1'b0);

    repeat (4) @(negedge clk);
    finish();
  end
endmodule